// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 32-bit virtual address into a physical address by reading one entry of a flat page table held in ordinary memory. A requester hands over a virtual address and an access kind (read, write or instruction fetch). At the moment the request is taken, the block also samples two plain control inputs: the table base address and the table length, the latter counted in entries. The block first checks the page number against the length. It then reads the 32-bit entry at base plus four times the page number and checks the entry's valid bit and protection field. When the access is allowed and the referenced or modified bit has to change, it writes the updated entry back. Last, it returns either the physical address or a fault code.

The block handles one request at a time. The request side and the response side are both valid/ready streams. A request is taken in the cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response for that request has been taken. A response is held with all of its fields unchanged for as long as `rsp_ready` stays low.

The memory port works as a command stream. A command is held steady until `mem_req_ready` is high. A read command is answered later by one cycle with `mem_rsp_valid` high, and that response has no back-pressure. A write command needs no answer.

Entry layout:
- bit 31: valid
- bit 30: referenced
- bit 29: modified
- bits 28:27: protection
- bits 26:20: reserved, carried through unchanged
- bits 19:0: page frame number

Top module: `pgx_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. Once a request has been taken, `req_ready` stays 0 until the response handshake.
- R2: For a page number below the length, the block issues exactly one memory read. Its address is `tbl_base + 4*page_number`. The page number is `req_vaddr[31:12]` and the offset is `req_vaddr[11:0]`.
- R3: A page number greater than or equal to `tbl_len` returns fault code 1 (length) with `rsp_paddr` = 0, and the block makes no memory access at all.
- R4: An entry whose bit 31 (valid) is 0 returns fault code 2 (invalid) with `rsp_paddr` = 0. The invalid fault takes precedence over any protection check.
- R5: The protection field in bits 28:27 is coded 00 read-only, 01 read-write, 10 execute-only and 11 read-write-execute. Access kinds are coded 0 read, 1 write and 2 fetch, and kind code 3 is never allowed. A read needs a code other than 10, a write needs 01 or 11, and a fetch needs 10 or 11. Any other combination returns fault code 3 (protection) with `rsp_paddr` = 0.
- R6: A permitted access returns fault code 0, with `rsp_paddr` formed as the frame number (entry bits 19:0) above the unchanged 12-bit offset.
- R7: A permitted access sets bit 30 (referenced), and a permitted write also sets bit 29 (modified). The entry is written back to the same address only when one of those bits changes value. All other bits, reserved bits included, are written back as they were read.
- R8: A faulting translation never writes to memory.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| tbl_base | input | 32 | Byte address of entry 0 of the table |
| tbl_len | input | 21 | Number of entries in the table |
| mem_req_valid | output | 1 | Memory command present |
| mem_req_ready | input | 1 | Memory takes the command |
| mem_req_we | output | 1 | 1 for a write command, 0 for a read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data present, one cycle |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |

## Verification
A length fault is due at `rsp_valid` one cycle after the request is taken. Every other result is due one cycle after the read data returns, or one cycle after the write-back is taken when a write-back is needed. Random stalls on `mem_req_ready` and `rsp_ready` move those points around. For that reason the scoreboard does not wait a fixed number of cycles: it pops its expected item at the response handshake, and it samples on the falling edge before the rising edge that completes the transfer. At the same point it checks the memory model's entry word, how many reads and writes the model counted, and the address of the last read, so that both the write-back rules and the absence of an access are observed at the ports.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  // Access kind codes
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  // Fault codes
  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_LEN  = 2'd1;
  localparam logic [1:0] FLT_INV  = 2'd2;
  localparam logic [1:0] FLT_PROT = 2'd3;

  // Protection codes
  localparam logic [1:0] PR_RO  = 2'b00;
  localparam logic [1:0] PR_RW  = 2'b01;
  localparam logic [1:0] PR_XO  = 2'b10;
  localparam logic [1:0] PR_RWX = 2'b11;

  // Entry bit positions
  localparam int PTE_VLD  = 31;
  localparam int PTE_REF  = 30;
  localparam int PTE_MOD  = 29;
  localparam int PTE_PRHI = 28;
  localparam int PTE_PRLO = 27;
endpackage

// File: rtl/pgx_split.sv
module pgx_split #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int TA_W      = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int LEN_W    = VPN_W + 1
) (
  input  logic [VA_W-1:0]      vaddr,
  input  logic [TA_W-1:0]      base,
  input  logic [LEN_W-1:0]     len,
  output logic [PAGE_BITS-1:0] offset,
  output logic [TA_W-1:0]      ent_addr,
  output logic                 beyond
);
  logic [VPN_W-1:0] vpn;

  assign vpn      = vaddr[VA_W-1:PAGE_BITS];
  assign offset   = vaddr[PAGE_BITS-1:0];
  assign ent_addr = base + {{(TA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
  assign beyond   = ({1'b0, vpn} >= len);
endmodule

// File: rtl/pgx_check.sv
module pgx_check
  import pgx_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int PTE_W     = 32,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic [1:0]           kind,
  input  logic [PAGE_BITS-1:0] offset,
  output logic [1:0]           fault,
  output logic [PA_W-1:0]      paddr,
  output logic [PTE_W-1:0]     new_pte,
  output logic                 need_wb
);
  logic [1:0] prot;
  logic       allow;

  assign prot = pte[PTE_PRHI:PTE_PRLO];

  always_comb begin
    unique case (kind)
      ACC_READ:  allow = (prot != PR_XO);
      ACC_WRITE: allow = (prot == PR_RW) || (prot == PR_RWX);
      ACC_EXEC:  allow = (prot == PR_XO) || (prot == PR_RWX);
      default:   allow = 1'b0;
    endcase
  end

  always_comb begin
    if (!pte[PTE_VLD])  fault = FLT_INV;
    else if (!allow)    fault = FLT_PROT;
    else                fault = FLT_NONE;
  end

  always_comb begin
    new_pte          = pte;
    new_pte[PTE_REF] = 1'b1;
    if (kind == ACC_WRITE) new_pte[PTE_MOD] = 1'b1;
  end

  assign need_wb = (fault == FLT_NONE) && (new_pte != pte);
  assign paddr   = (fault == FLT_NONE) ? {pte[PFN_W-1:0], offset} : '0;
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
  import pgx_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int TA_W      = 32,
  parameter int PTE_W     = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int LEN_W    = VPN_W + 1,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [TA_W-1:0]  tbl_base,
  input  logic [LEN_W-1:0] tbl_len,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [TA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_RESP} st_e;
  st_e st;

  logic [PAGE_BITS-1:0] sp_off, off_q;
  logic [TA_W-1:0]      sp_addr, ent_addr_q;
  logic                 sp_beyond;
  logic [1:0]           kind_q, flt_q, ck_flt;
  logic [PA_W-1:0]      paddr_q, ck_paddr;
  logic [PTE_W-1:0]     wpte_q, ck_pte;
  logic                 ck_wb;

  pgx_split #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .TA_W(TA_W)) u_split (
    .vaddr(req_vaddr), .base(tbl_base), .len(tbl_len),
    .offset(sp_off), .ent_addr(sp_addr), .beyond(sp_beyond)
  );

  pgx_check #(.PAGE_BITS(PAGE_BITS), .PFN_W(PFN_W), .PTE_W(PTE_W)) u_check (
    .pte(mem_rsp_rdata), .kind(kind_q), .offset(off_q),
    .fault(ck_flt), .paddr(ck_paddr), .new_pte(ck_pte), .need_wb(ck_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      off_q      <= '0;
      ent_addr_q <= '0;
      kind_q     <= ACC_READ;
      flt_q      <= FLT_NONE;
      paddr_q    <= '0;
      wpte_q     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          kind_q     <= req_kind;
          off_q      <= sp_off;
          ent_addr_q <= sp_addr;
          if (sp_beyond) begin
            flt_q   <= FLT_LEN;
            paddr_q <= '0;
            st      <= S_RESP;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          flt_q   <= ck_flt;
          paddr_q <= ck_paddr;
          wpte_q  <= ck_pte;
          st      <= ck_wb ? S_WB : S_RESP;
        end
        S_WB: if (mem_req_ready) st <= S_RESP;
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD) || (st == S_WB);
  assign mem_req_we    = (st == S_WB);
  assign mem_req_addr  = ent_addr_q;
  assign mem_req_wdata = wpte_q;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = flt_q;

  // R1: one outstanding request
  p_one_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: length fault without memory traffic
  p_len_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1:PAGE_BITS]} >= tbl_len))
    |=> (rsp_valid && rsp_fault == FLT_LEN && !mem_req_valid));

  // R4: faults carry a zero address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R2: memory command held until taken
  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
    (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  // R7: a write-back always marks the entry referenced
  p_wb_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[PTE_REF]);

  // R8: no write-back for a faulting translation
  p_fault_nowb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (flt_q == FLT_NONE));

  // R9: response stable under back-pressure
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
    (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

// File: tb/sim_pgx_walker.sv
module sim_pgx_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [20:0] LEN  = 21'd20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .tbl_base(BASE), .tbl_len(LEN),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory model
  logic [31:0] mem [0:63];
  int rd_cnt, wr_cnt, cyc;
  logic [31:0] last_raddr;

  function automatic logic [31:0] init_word(input int i);
    case (i)
      16: return 32'h8001_2345; // page 0 read-only
      17: return 32'h880A_BCDE; // page 1 read-write
      18: return 32'h9000_0777; // page 2 execute-only
      19: return 32'h9DAF_FFFF; // page 3 rwx, reserved bits set
      20: return 32'h1805_4321; // page 4 not valid
      35: return 32'h8800_0001; // page 19 read-write, last entry
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      rd_cnt <= 0; wr_cnt <= 0; last_raddr <= '0;
      mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[7:2]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_cnt <= rd_cnt + 1;
          last_raddr <= mem_req_addr;
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[mem_req_addr[7:2]];
        end
      end
    end
  end

  initial cyc = 0;

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  flt;
    int          idx;
    logic [31:0] pte_after;
    int          rds;
    int          wrs;
    int          rd0;
    int          wr0;
    logic [31:0] raddr;
    string       tag;
  } exp_t;
  exp_t q[$];

  // Driver: expectations from the requirements
  task automatic go(input int vpn, input logic [11:0] off, input logic [1:0] kind, input string tag);
    exp_t e;
    logic [31:0] w;
    logic [1:0] p;
    bit allow;
    e.tag = tag; e.rd0 = rd_cnt; e.wr0 = wr_cnt;
    e.raddr = BASE + 32'(vpn) * 4;
    if (vpn >= int'(LEN)) begin
      e.flt = 2'd1; e.paddr = 0; e.idx = -1; e.pte_after = 0; e.rds = 0; e.wrs = 0;
    end else begin
      e.idx = 16 + vpn;
      w = mem[e.idx];
      p = w[28:27];
      case (kind)
        2'd0: allow = (p != 2'b10);
        2'd1: allow = (p == 2'b01) || (p == 2'b11);
        2'd2: allow = (p == 2'b10) || (p == 2'b11);
        default: allow = 1'b0;
      endcase
      e.rds = 1;
      e.pte_after = w;
      e.wrs = 0;
      if (!w[31]) begin e.flt = 2'd2; e.paddr = 0; end
      else if (!allow) begin e.flt = 2'd3; e.paddr = 0; end
      else begin
        e.flt = 2'd0;
        e.paddr = {w[19:0], off};
        e.pte_after[30] = 1'b1;
        if (kind == 2'd1) e.pte_after[29] = 1'b1;
        e.wrs = (e.pte_after != w) ? 1 : 0;
      end
    end
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn[19:0], off};
    req_kind  = kind;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "req_ready while busy", {31'b0, req_ready}, 32'h0);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor and back-pressure patterns
  bit held = 0;
  logic [31:0] h_paddr;
  logic [1:0]  h_flt;

  always @(negedge clk) begin
    exp_t e;
    rsp_ready = (cyc % 4) != 1;
    mem_req_ready = (cyc % 5) != 2;
    if (rst_n && rsp_valid) begin
      if (held) begin
        chk(rsp_paddr == h_paddr && rsp_fault == h_flt, "R9", "held response",
            rsp_paddr, h_paddr);
      end
      if (!rsp_ready) begin
        held = 1; h_paddr = rsp_paddr; h_flt = rsp_fault;
      end else begin
        held = 0;
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected response", {30'b0, rsp_fault}, 32'h0);
        end else begin
          e = q.pop_front();
          chk(rsp_fault == e.flt, e.tag, "fault code", {30'b0, rsp_fault}, {30'b0, e.flt});
          chk(rsp_paddr == e.paddr, e.tag, "paddr", rsp_paddr, e.paddr);
          chk(rd_cnt - e.rd0 == e.rds, (e.flt == 2'd1) ? "R3" : "R2", "read count",
              32'(rd_cnt - e.rd0), 32'(e.rds));
          chk(wr_cnt - e.wr0 == e.wrs, (e.flt != 2'd0) ? "R8" : "R7", "write count",
              32'(wr_cnt - e.wr0), 32'(e.wrs));
          if (e.idx >= 0) begin
            chk(last_raddr == e.raddr, "R2", "entry address", last_raddr, e.raddr);
            chk(mem[e.idx] == e.pte_after, (e.flt != 2'd0) ? "R8" : "R7", "stored entry",
                mem[e.idx], e.pte_after);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    while (cyc < 20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", {31'b0, mem_req_valid}, 32'h0);

    go(0, 12'h0AB, 2'd0, "R6");   // read on read-only, sets referenced
    go(0, 12'h001, 2'd0, "R7");   // again: no write-back
    go(0, 12'h002, 2'd1, "R5");   // write on read-only
    go(0, 12'h003, 2'd2, "R5");   // fetch on read-only
    go(1, 12'hFFF, 2'd1, "R7");   // write on read-write: referenced and modified
    go(1, 12'h010, 2'd0, "R6");   // read, nothing changes
    go(1, 12'h010, 2'd2, "R5");   // fetch on read-write
    go(2, 12'h123, 2'd2, "R6");   // fetch on execute-only
    go(2, 12'h124, 2'd0, "R5");   // read on execute-only
    go(3, 12'h456, 2'd0, "R7");   // rwx read, reserved preserved
    go(3, 12'h457, 2'd1, "R7");   // rwx write adds modified
    go(3, 12'h458, 2'd2, "R6");   // rwx fetch, no write-back
    go(3, 12'h459, 2'd3, "R5");   // kind code 3 never allowed
    go(4, 12'h000, 2'd0, "R4");   // invalid entry
    go(19, 12'hFFF, 2'd0, "R6");  // last entry in range
    go(20, 12'h000, 2'd0, "R3");  // page number equal to length
    go(32'hFFFFF, 12'h000, 2'd1, "R3"); // far beyond
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule